// File: doc/BRIEF.md
# Input Arrival-Order Detector

This block watches two level inputs, an arming line and a firing line, and raises a single flag when both are high and the arming line got there first. Once raised, the flag stays high for as long as the firing line stays high, whatever the arming line does. It drops only when the firing line falls. If the firing line rises first, or both lines rise in the same sample period, the flag stays low.

The block samples its inputs on the rising clock edge. By default each input first passes through a two-flop synchronizer, so either line may come from another clock domain or from an external pin. The order is kept in one memory bit, called the armed bit. This bit is set when the sampled firing line is low and the arming line is high. It is cleared when both sampled lines are low. It is left unchanged whenever the firing line is high. The flag is the sampled firing line ANDed with the armed bit. An active-high synchronous reset clears the armed bit. All pins are plain level signals, with no handshake.

Top module: `order_watch`

## Requirements
- R1: While `rst` is high, and after it is released with both inputs low, `hit_o` is 0.
- R2: If the sampled inputs pass from (fire=0, arm=1) to (fire=1, arm=1), `hit_o` becomes 1.
- R3: If the firing line rises while the arming line is low, and the arming line rises afterwards, `hit_o` stays 0.
- R4: A jump from both inputs low to both inputs high within one sample period leaves `hit_o` at 0.
- R5: While `hit_o` is 1 and `fire_i` stays 1, a fall of `arm_i` leaves `hit_o` at 1.
- R6: A fall of `fire_i` clears `hit_o`. If `fire_i` then rises again without the arming line ever having been sampled low together with the firing line, `hit_o` comes back only when the arming line is still high.
- R7: The armed bit is set by the sampled pair (fire=0, arm=1), cleared by (0,0), and held by any pair with fire=1. `hit_o` is the sampled fire ANDed with the armed bit, for every input sequence.
- R8: With `SYNC_STAGES`=2, a change on `fire_i` shows on `hit_o` after exactly two rising clock edges. It does not show after one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fire_i | input | 1 | Firing line, level, may be asynchronous |
| arm_i | input | 1 | Arming line, level, may be asynchronous |
| hit_o | output | 1 | High while fire is held after arm rose first |

## Verification
The main sweep starts every run from reset and applies all sequences of four input pairs. Each pair is held long enough to settle. The result is compared with an order-tracking model after every step. This set of sequences covers arm-then-fire, fire-then-arm, the simultaneous jump and the release orderings, so it separates true ordering from a plain level AND and from a detector that forgets the order after the arming line falls. Directed runs fix the two-edge latency and check that reset in the middle of a hit clears the flag.

// File: rtl/order_watch_pkg.sv
package order_watch_pkg;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_ARMED = 1'b1
  } arm_state_t;

  typedef struct packed {
    logic fire;
    logic arm;
  } pair_t;

  localparam int PAIR_W = $bits(pair_t);

endpackage

// File: rtl/order_watch_sync.sv
module order_watch_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign dout = din;
    end else begin : g_chain
      logic [W-1:0] stg [STAGES];

      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
          stg[0] <= din;
          for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
      end

      assign dout = stg[STAGES-1];

      AST_SYNC_FIRST: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> stg[0] == $past(din)); // R8
    end
  endgenerate

endmodule

// File: rtl/order_watch_fsm.sv
module order_watch_fsm
  import order_watch_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  pair_t smp,
  output logic hit
);

  arm_state_t state, nxt;

  always_comb begin
    unique case ({smp.fire, smp.arm})
      2'b01:   nxt = ST_ARMED;
      2'b00:   nxt = ST_IDLE;
      default: nxt = state;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end

  assign hit = smp.fire & (state == ST_ARMED);

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> state == ST_IDLE); // R1
  AST_ARM_SETS: assert property (@(posedge clk) disable iff (rst)
    (!smp.fire && smp.arm) |=> state == ST_ARMED); // R7
  AST_BOTH_LOW_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (!smp.fire && !smp.arm) |=> state == ST_IDLE); // R7
  AST_FIRE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    smp.fire |=> $stable(state)); // R5
  AST_HIT_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (hit && smp.fire) |=> (hit || !smp.fire)); // R5

endmodule

// File: rtl/order_watch.sv
module order_watch
  import order_watch_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic fire_i,
  input  logic arm_i,
  output logic hit_o
);

  pair_t raw, smp;
  logic [PAIR_W-1:0] smp_bits;

  assign raw = '{fire: fire_i, arm: arm_i};

  order_watch_sync #(
    .W      (PAIR_W),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (raw),
    .dout (smp_bits)
  );

  assign smp = pair_t'(smp_bits);

  order_watch_fsm u_fsm (
    .clk (clk),
    .rst (rst),
    .smp (smp),
    .hit (hit_o)
  );

  AST_FALL_DROPS: assert property (@(posedge clk) disable iff (rst)
    $fell(smp.fire) |-> !hit_o); // R6

endmodule

// File: tb/order_watch_test.sv
module order_watch_test;

  localparam int LAT = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fire_i = 1'b0;
  logic arm_i = 1'b0;
  logic hit_o;

  int n_run = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  order_watch #(.SYNC_STAGES(LAT)) uut (
    .clk(clk), .rst(rst), .fire_i(fire_i), .arm_i(arm_i), .hit_o(hit_o)
  );

  task automatic check(input string req, input logic exp);
    n_run++;
    if (hit_o !== exp) begin
      n_bad++;
      $display("FAIL %s: hit_o=%b expected=%b at %0t", req, hit_o, exp, $time);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic drive(input logic f, input logic a);
    @(negedge clk);
    fire_i = f;
    arm_i  = a;
    cycles(LAT + 2);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; fire_i = 1'b0; arm_i = 1'b0;
    cycles(3);
    @(negedge clk);
    rst = 1'b0;
    cycles(1);
  endtask

  initial begin
    #1;
    cycles(2);
    check("R1", 1'b0);
    do_reset();
    check("R1", 1'b0);

    // R2: arm first, then fire
    drive(1'b0, 1'b1); check("R2", 1'b0);
    drive(1'b1, 1'b1); check("R2", 1'b1);
    // R5: arm falls while fire stays high
    drive(1'b1, 1'b0); check("R5", 1'b1);
    // R6: fire falls clears
    drive(1'b0, 1'b0); check("R6", 1'b0);
    drive(1'b1, 1'b0); check("R6", 1'b0);

    // R3: fire first, then arm
    do_reset();
    drive(1'b1, 1'b0); check("R3", 1'b0);
    drive(1'b1, 1'b1); check("R3", 1'b0);

    // R4: direct jump 00 -> 11
    do_reset();
    drive(1'b1, 1'b1); check("R4", 1'b0);

    // R6: 11 -> 01 -> 11 rearms via arm still high
    do_reset();
    drive(1'b0, 1'b1); drive(1'b1, 1'b1); check("R6", 1'b1);
    drive(1'b0, 1'b1); check("R6", 1'b0);
    drive(1'b1, 1'b1); check("R6", 1'b1);

    // R8: latency of fire change
    do_reset();
    drive(1'b0, 1'b1);
    @(negedge clk); fire_i = 1'b1;
    cycles(1); check("R8", 1'b0);
    cycles(1); check("R8", 1'b1);
    @(negedge clk); fire_i = 1'b0;
    cycles(1); check("R8", 1'b1);
    cycles(1); check("R8", 1'b0);

    // R1: reset in the middle of a hit
    drive(1'b1, 1'b1); check("R1", 1'b1);
    @(negedge clk); rst = 1'b1;
    cycles(1); check("R1", 1'b0);
    @(negedge clk); rst = 1'b0; fire_i = 1'b0; arm_i = 1'b0;
    cycles(1);

    // R7: every sequence of four input pairs
    for (int seq = 0; seq < 256; seq++) begin
      logic armed;
      do_reset();
      armed = 1'b0;
      for (int s = 0; s < 4; s++) begin
        logic f, a;
        f = seq[2*s+1];
        a = seq[2*s];
        if (!f) armed = a;
        drive(f, a);
        check("R7", f & armed);
      end
    end

    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

endmodule